// File: doc/BRIEF.md
# Calendar Timekeeper with Alarm Match

This block keeps a binary calendar made of seconds, minutes, hours, day of week, day of month, month and a two-digit year. A one-pulse-per-second strobe from elsewhere in the chip advances it. Every field of the new time is computed and loaded on the same clock edge that samples the strobe. Software reaches the running time, a second set of alarm fields, a stop control, an alarm control and an interrupt status through a byte-wide register port with a one-cycle read latency.

The time fields and the alarm fields use one address rule. Field f of set s sits at 0x40 + 4·f + 0x20·s. Set 0 is the running time and set 1 is the alarm. The field order is year, month, day of month, day of week, hour, minute, second. Software stops the counter, writes the time fields, and then restarts it.

After each advance, the block compares the new time against the alarm fields that the alarm control selects. A match sets a sticky status bit, which software clears by writing a one to it. The interrupt line is that status gated by the alarm enable.

Top module: `tkc_top`

## Requirements
- R1: Time field f is at byte address 0x40+4·f and alarm field f is at 0x60+4·f, with f = 0 year, 1 month, 2 day of month, 3 day of week, 4 hour, 5 minute, 6 second. A read with `rd_en` returns the value on `rd_data` with `rd_valid` one cycle later. Alarm fields can be written at any time.
- R2: After reset the stop bit is 1, the time is year 0, month 1, day 1, weekday 0, 00:00:00, the alarm control is 0x00, the status is clear and `irq` is 0.
- R3: Bit 0 of the register at 0x20 is the stop bit. While it is 1, `tick` is ignored and writes to time fields are accepted. While it is 0, writes to time fields are ignored.
- R4: On an accepted tick the second goes from 59 to 0 and carries into the minute. The minute goes from 59 to 0 and carries into the hour, and the hour goes from 23 to 0 and carries into the day. All fields change on the edge that samples the tick.
- R5: The day of month wraps to 1 after day 30 in months 4, 6, 9 and 11, and after day 31 in the other months except February. Month 12 wraps to 1 and carries into the year. The day of week counts 0 to 6 and wraps, and it advances on every day roll.
- R6: February has 29 days when the year is a nonzero multiple of 4. It has 28 days in all other years, including year 0.
- R7: The year counts up to 99 and wraps to 0.
- R8: At 0x7C, bit 0 enables the alarm and bit f+1 enables the compare of field f. The alarm fires on an accepted tick whose new time equals every enabled alarm field. With bit 0 clear, nothing fires.
- R9: Bit 4 of the register at 0x30 is the alarm status. A fire sets it, and it stays set until a write with bit 4 = 1. A write with bit 4 = 0 leaves it set.
- R10: `irq` is 1 exactly when the status is set and alarm-control bit 0 is set. It rises on the edge that sets the status. Writing 0x00 to 0x7C drops `irq` while the status stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse once per second |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address for the read or write |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data is present this cycle |
| irq | output | 1 | Alarm interrupt |

## Verification
The bench drives the calendar through the edges where carries ripple furthest:
- end of year 99, which must wrap to year 0, January 1, rather than reach 100;
- end of June, which must not reach day 31;
- February in year 4, in year 0 and in year 1, where a wrong leap rule lands on the wrong day.

It also checks that time writes made while running leave the time unchanged and that ticks during a stop are ignored. On the alarm side it checks a one-field match and a full seven-field match. It checks that a mismatch in a masked-in field suppresses the fire, and that a cleared enable bit suppresses it with all compares on. It checks that the status survives a zero write but clears on a one. Finally it checks that disabling the alarm drops `irq` with the status still pending; a design that failed here would keep interrupting or lose the event.

// File: rtl/tkc_pkg.sv
package tkc_pkg;
  localparam int NFLD     = 7;
  localparam int FI_YEAR  = 0;
  localparam int FI_MON   = 1;
  localparam int FI_DOM   = 2;
  localparam int FI_DOW   = 3;
  localparam int FI_HOUR  = 4;
  localparam int FI_MIN   = 5;
  localparam int FI_SEC   = 6;

  localparam logic [7:0] A_CTRL  = 8'h20;
  localparam logic [7:0] A_INT   = 8'h30;
  localparam logic [7:0] A_ALCTL = 8'h7C;
  localparam int         INT_BIT = 4;

  function automatic logic [4:0] month_len(input logic [3:0] m, input logic leap);
    case (m)
      4'd2:                    return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      default:                 return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/tkc_calendar.sv
module tkc_calendar
  import tkc_pkg::*;
#(
  parameter int DW        = 8,
  parameter int YEAR_LAST = 99
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     adv,
  input  logic                     ld_en,
  input  logic [2:0]               ld_idx,
  input  logic [DW-1:0]            ld_val,
  output logic [NFLD-1:0][DW-1:0]  cur,
  output logic [NFLD-1:0][DW-1:0]  nxt
);
  logic sec_w, min_w, hr_w, day_w, mon_w, leap;
  logic [4:0] dlen;

  always_comb begin
    leap  = (cur[FI_YEAR][1:0] == 2'b00) && (cur[FI_YEAR] != '0);
    dlen  = month_len(cur[FI_MON][3:0], leap);
    sec_w = cur[FI_SEC] >= DW'(59);
    min_w = sec_w && (cur[FI_MIN] >= DW'(59));
    hr_w  = min_w && (cur[FI_HOUR] >= DW'(23));
    day_w = hr_w && (cur[FI_DOM] >= DW'(dlen));
    mon_w = day_w && (cur[FI_MON] >= DW'(12));

    nxt = cur;
    nxt[FI_SEC] = sec_w ? '0 : cur[FI_SEC] + DW'(1);
    if (sec_w) nxt[FI_MIN]  = (cur[FI_MIN] >= DW'(59)) ? '0 : cur[FI_MIN] + DW'(1);
    if (min_w) nxt[FI_HOUR] = (cur[FI_HOUR] >= DW'(23)) ? '0 : cur[FI_HOUR] + DW'(1);
    if (hr_w) begin
      nxt[FI_DOM] = (cur[FI_DOM] >= DW'(dlen)) ? DW'(1) : cur[FI_DOM] + DW'(1);
      nxt[FI_DOW] = (cur[FI_DOW] >= DW'(6)) ? '0 : cur[FI_DOW] + DW'(1);
    end
    if (day_w) nxt[FI_MON]  = (cur[FI_MON] >= DW'(12)) ? DW'(1) : cur[FI_MON] + DW'(1);
    if (mon_w) nxt[FI_YEAR] = (cur[FI_YEAR] >= DW'(YEAR_LAST)) ? '0 : cur[FI_YEAR] + DW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur          <= '0;
      cur[FI_MON]  <= DW'(1);
      cur[FI_DOM]  <= DW'(1);
    end else if (ld_en) begin
      cur[ld_idx]  <= ld_val;
    end else if (adv) begin
      cur          <= nxt;
    end
  end
endmodule

// File: rtl/tkc_alarm.sv
module tkc_alarm
  import tkc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     adv,
  input  logic [NFLD-1:0][DW-1:0]  nxt,
  input  logic                     al_wr,
  input  logic [2:0]               al_idx,
  input  logic [DW-1:0]            al_val,
  input  logic                     ctl_wr,
  input  logic [NFLD:0]            ctl_val,
  input  logic                     clr,
  output logic [NFLD-1:0][DW-1:0]  al_q,
  output logic [NFLD:0]            ctl_q,
  output logic                     st_q,
  output logic                     irq_q
);
  logic [NFLD-1:0] fld_ok;
  logic            hit, st_n;
  logic [NFLD:0]   ctl_n;

  for (genvar f = 0; f < NFLD; f++) begin : g_cmp
    assign fld_ok[f] = ~ctl_q[f+1] | (nxt[f] == al_q[f]);
  end

  assign hit   = adv & ctl_q[0] & (&fld_ok);
  assign st_n  = hit | (st_q & ~clr);
  assign ctl_n = ctl_wr ? ctl_val : ctl_q;

  always_ff @(posedge clk) begin
    if (al_wr) al_q[al_idx] <= al_val;
    if (rst) begin
      ctl_q <= '0;
      st_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ctl_q <= ctl_n;
      st_q  <= st_n;
      irq_q <= st_n & ctl_n[0];
    end
  end
endmodule

// File: rtl/tkc_top.sv
module tkc_top
  import tkc_pkg::*;
#(
  parameter int DW        = 8,
  parameter int AW        = 8,
  parameter int YEAR_LAST = 99
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          irq
);
  logic [2:0] fidx;
  logic is_t, is_a, is_ctrl, is_int, is_alctl;
  logic stop_q, adv, ld_en, time_wr_req, int_clr;
  logic [NFLD-1:0][DW-1:0] cur, nxt, al_q;
  logic [NFLD:0] alctl;
  logic st_q;
  logic [DW-1:0] rmux;

  assign fidx     = addr[4:2];
  assign is_t     = (addr[AW-1:5] == 3'b010) && (addr[1:0] == 2'b00) && (fidx != 3'd7);
  assign is_a     = (addr[AW-1:5] == 3'b011) && (addr[1:0] == 2'b00) && (fidx != 3'd7);
  assign is_ctrl  = addr == A_CTRL;
  assign is_int   = addr == A_INT;
  assign is_alctl = addr == A_ALCTL;

  assign adv         = tick & ~stop_q;
  assign time_wr_req = wr_en & is_t;
  assign ld_en       = time_wr_req & stop_q;
  assign int_clr     = wr_en & is_int & wdata[INT_BIT];

  always_ff @(posedge clk) begin
    if (rst) stop_q <= 1'b1;
    else if (wr_en && is_ctrl) stop_q <= wdata[0];
  end

  tkc_calendar #(.DW(DW), .YEAR_LAST(YEAR_LAST)) u_cal (
    .clk(clk), .rst(rst), .adv(adv), .ld_en(ld_en), .ld_idx(fidx),
    .ld_val(wdata), .cur(cur), .nxt(nxt)
  );

  tkc_alarm #(.DW(DW)) u_alm (
    .clk(clk), .rst(rst), .adv(adv), .nxt(nxt),
    .al_wr(wr_en & is_a), .al_idx(fidx), .al_val(wdata),
    .ctl_wr(wr_en & is_alctl), .ctl_val(wdata[NFLD:0]), .clr(int_clr),
    .al_q(al_q), .ctl_q(alctl), .st_q(st_q), .irq_q(irq)
  );

  always_comb begin
    rmux = '0;
    if (is_t)          rmux = cur[fidx];
    else if (is_a)     rmux = al_q[fidx];
    else if (is_ctrl)  rmux[0] = stop_q;
    else if (is_int)   rmux[INT_BIT] = st_q;
    else if (is_alctl) rmux[NFLD:0] = alctl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rmux;
    end
  end
endmodule

// File: rtl/tkc_top_chk.sv
module tkc_top_chk
  import tkc_pkg::*;
#(
  parameter int DW        = 8,
  parameter int YEAR_LAST = 99
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    adv,
  input logic                    stop_q,
  input logic                    ld_en,
  input logic                    time_wr_req,
  input logic                    int_clr,
  input logic [NFLD-1:0][DW-1:0] cur,
  input logic                    st_q,
  input logic [NFLD:0]           alctl,
  input logic                    irq
);
  assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (rst)
    (stop_q && !ld_en) |=> $stable(cur));

  assert_run_write_dropped_R3: assert property (@(posedge clk) disable iff (rst)
    (!stop_q && time_wr_req && !adv) |=> $stable(cur));

  assert_sec_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (adv && cur[FI_SEC] == DW'(59)) |=> (cur[FI_SEC] == '0));

  assert_year_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (adv && cur[FI_YEAR] == DW'(YEAR_LAST) && cur[FI_MON] == DW'(12) &&
     cur[FI_DOM] == DW'(31) && cur[FI_HOUR] == DW'(23) &&
     cur[FI_MIN] == DW'(59) && cur[FI_SEC] == DW'(59)) |=> (cur[FI_YEAR] == '0));

  assert_no_fire_disabled_R8: assert property (@(posedge clk) disable iff (rst)
    (!alctl[0] && !st_q) |=> !st_q);

  assert_status_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (st_q && !int_clr) |=> st_q);

  assert_irq_needs_status_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> (st_q && alctl[0]));
endmodule

bind tkc_top tkc_top_chk #(.DW(DW), .YEAR_LAST(YEAR_LAST)) u_chk (
  .clk(clk), .rst(rst), .adv(adv), .stop_q(stop_q), .ld_en(ld_en),
  .time_wr_req(time_wr_req), .int_clr(int_clr), .cur(cur), .st_q(st_q),
  .alctl(alctl), .irq(irq)
);

// File: tb/tkc_top_test.sv
module tkc_top_test;
  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rd_data;
  logic rd_valid, irq;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] exp; string tag; logic [7:0] a; } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  tkc_top uut (.clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
               .addr(addr), .wdata(wdata), .rd_data(rd_data), .rd_valid(rd_valid), .irq(irq));

  always @(negedge clk) begin
    if (rd_valid) begin
      if (sb.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL R1 unexpected read data act=%h exp=none", rd_data);
      end else begin
        exp_t e;
        e = sb.pop_front();
        n_chk++;
        if (rd_data !== e.exp) begin
          n_err++;
          $display("FAIL %s addr=%h act=%h exp=%h", e.tag, e.a, rd_data, e.exp);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    exp_t x;
    x.exp = e; x.tag = tag; x.a = a;
    @(negedge clk); rd_en = 1'b1; addr = a; sb.push_back(x);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic chk(input string tag, input logic act, input logic e);
    n_chk++;
    if (act !== e) begin
      n_err++;
      $display("FAIL %s act=%b exp=%b", tag, act, e);
    end
  endtask

  task automatic load(input int y, mo, d, w, h, mi, s);
    wr(8'h20, 8'h01);
    wr(8'h40, 8'(y)); wr(8'h44, 8'(mo)); wr(8'h48, 8'(d)); wr(8'h4C, 8'(w));
    wr(8'h50, 8'(h)); wr(8'h54, 8'(mi)); wr(8'h58, 8'(s));
  endtask

  task automatic rd_time(input int y, mo, d, w, h, mi, s, input string tag);
    rd(8'h40, 8'(y), tag); rd(8'h44, 8'(mo), tag); rd(8'h48, 8'(d), tag);
    rd(8'h4C, 8'(w), tag); rd(8'h50, 8'(h), tag); rd(8'h54, 8'(mi), tag);
    rd(8'h58, 8'(s), tag);
  endtask

  task automatic step_from(input int y, mo, d, w, input int y2, mo2, d2, w2, input string tag);
    load(y, mo, d, w, 23, 59, 59);
    wr(8'h20, 8'h00);
    pulse();
    rd_time(y2, mo2, d2, w2, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R2 reset state
    chk("R2 irq after reset", irq, 1'b0);
    rd(8'h20, 8'h01, "R2 stop reset");
    rd_time(0, 1, 1, 0, 0, 0, 0, "R2 time reset");
    rd(8'h7C, 8'h00, "R2 alarm ctl reset");
    rd(8'h30, 8'h00, "R2 status reset");
    // R3 tick ignored while stopped
    pulse();
    rd(8'h58, 8'h00, "R3 stopped tick ignored");
    // R1 R3 load while stopped, R4 R5 R7 year-end roll
    load(99, 12, 31, 6, 23, 59, 58);
    rd_time(99, 12, 31, 6, 23, 59, 58, "R1 time readback");
    wr(8'h20, 8'h00);
    pulse();
    rd(8'h58, 8'd59, "R4 one second");
    pulse();
    rd_time(0, 1, 1, 0, 0, 0, 0, "R7 year 99 wraps to 0");
    // R3 write while running ignored
    wr(8'h58, 8'h21);
    rd(8'h58, 8'h00, "R3 running write ignored");
    pulse();
    rd(8'h58, 8'h01, "R4 counting after ignored write");
    // R5 month lengths, R6 leap rule
    step_from(5, 6, 30, 2, 5, 7, 1, 3, "R5 30-day month");
    step_from(7, 1, 31, 6, 7, 2, 1, 0, "R5 31-day month dow wrap");
    step_from(4, 2, 28, 1, 4, 2, 29, 2, "R6 leap year 4");
    step_from(4, 2, 29, 2, 4, 3, 1, 3, "R6 leap end of feb");
    step_from(0, 2, 28, 4, 0, 3, 1, 5, "R6 year 0 not leap");
    step_from(1, 2, 28, 4, 1, 3, 1, 5, "R6 year 1 not leap");
    // R8 single-field alarm
    load(0, 1, 1, 0, 0, 0, 3);
    wr(8'h20, 8'h00);
    wr(8'h78, 8'd5);
    wr(8'h7C, 8'h81);
    rd(8'h78, 8'd5, "R1 alarm readback");
    pulse();
    chk("R8 no fire on mismatch", irq, 1'b0);
    rd(8'h30, 8'h00, "R8 status clear before match");
    pulse();
    chk("R10 irq on match", irq, 1'b1);
    rd(8'h30, 8'h10, "R8 status on match");
    pulse();
    chk("R9 irq sticky", irq, 1'b1);
    wr(8'h30, 8'h00);
    rd(8'h30, 8'h10, "R9 zero write keeps status");
    wr(8'h30, 8'h10);
    rd(8'h30, 8'h00, "R9 w1c clears");
    chk("R10 irq after clear", irq, 1'b0);
    // R10 disable drops irq, status pending
    wr(8'h78, 8'd7);
    pulse();
    chk("R10 irq on second match", irq, 1'b1);
    wr(8'h7C, 8'h00);
    chk("R10 irq off after disable", irq, 1'b0);
    rd(8'h30, 8'h10, "R10 status stays pending");
    wr(8'h30, 8'h10);
    // R8 enable bit clear suppresses
    wr(8'h78, 8'd8);
    wr(8'h7C, 8'hFE);
    pulse();
    chk("R8 enable clear no irq", irq, 1'b0);
    rd(8'h30, 8'h00, "R8 enable clear no status");
    // R8 full seven-field match
    wr(8'h60, 8'd0); wr(8'h64, 8'd1); wr(8'h68, 8'd1); wr(8'h6C, 8'd0);
    wr(8'h70, 8'd0); wr(8'h74, 8'd0); wr(8'h78, 8'd9);
    wr(8'h7C, 8'hFF);
    pulse();
    chk("R8 full match irq", irq, 1'b1);
    rd(8'h30, 8'h10, "R8 full match status");
    wr(8'h30, 8'h10);
    // R8 mismatch in enabled minute suppresses
    wr(8'h74, 8'd5); wr(8'h78, 8'd10);
    pulse();
    chk("R8 minute mismatch no irq", irq, 1'b0);
    rd(8'h30, 8'h00, "R8 minute mismatch no status");
    rd(8'h58, 8'd10, "R4 seconds after alarm run");
    repeat (4) @(negedge clk);
    if (sb.size() != 0) begin
      n_chk++; n_err++;
      $display("FAIL R1 missing read data act=%0d exp=0 pending", sb.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule